// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Dispatcher

This block sits beside a CPU core and decides when the core must break off to service an interrupt. It keeps a per-source enable register and a per-source pending register, and both are reachable through a small byte-wide register port. It also keeps a single global interrupt gate that the core opens and closes. Peripherals raise a one-cycle request pulse, and that pulse latches a pending bit. When the gate is open and some source is both enabled and pending, the block picks the lowest-numbered such source. In the same step it closes the gate and clears that source's pending bit, then raises a dispatch request toward the core. The request also serves as a wake signal for a halted core.

Once the core acknowledges the request, the block captures the current program counter and stack pointer. It then emits two byte writes that store the return address on the stack: the upper byte first at stack pointer minus one, then the lower byte at stack pointer minus two. Last, it presents the source's vector address and the updated stack pointer for one cycle.

Top module: `irq_dispatch`

## Requirements
- R1: A write to address 0xFFFF loads the low five bits of the data into the enable register, and a write to 0xFF0F loads the low five bits into the pending register. A read of 0xFFFF returns the enable bits with bits 7..5 as 0. A read of any other address returns 0.
- R2: A request pulse on source i sets pending bit i at the next clock edge. When a request and a register write to 0xFF0F fall in the same cycle, the requested bit ends up set.
- R3: A read of 0xFF0F returns the pending bits in bits 4..0 and returns 1 in bits 7..5.
- R4: A dispatch starts only while the block is idle, the global gate is open, and the bitwise AND of enable and pending is nonzero. Pending bits whose enable bit is 0 never cause a dispatch.
- R5: Among the sources that are both enabled and pending, the lowest-numbered one is serviced. The vector for source i is 0x0040 + 8*i.
- R6: At the edge where a dispatch starts, the global gate closes and only the serviced source's pending bit is cleared. A request for that same source in that same cycle sets the bit again.
- R7: The dispatch request stays high until the core acknowledges it. In the cycle after the acknowledge, a stack write carries PC[15:8] to SP-1. In the next cycle a stack write carries PC[7:0] to SP-2. In the cycle after that, the vector is valid and the new stack pointer SP-2 is output. The block then returns to idle.
- R8: The wake output is high exactly while the dispatch request is high.
- R9: The gate-open input opens the global gate at the next edge and the gate-close input closes it. When both inputs are asserted together, the gate closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 5 | One-cycle request pulses, one bit per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on bus_addr) |
| gate_open | input | 1 | Opens the global interrupt gate |
| gate_close | input | 1 | Closes the global interrupt gate |
| disp_ack | input | 1 | Core accepts the dispatch request |
| pc_in | input | 16 | Core program counter, captured at acknowledge |
| sp_in | input | 16 | Core stack pointer, captured at acknowledge |
| disp_req | output | 1 | Dispatch request to the core |
| wake | output | 1 | Releases a halted core |
| push_we | output | 1 | Stack byte write strobe |
| push_addr | output | 16 | Stack byte write address |
| push_data | output | 8 | Stack byte write data |
| vec_valid | output | 1 | Vector and new stack pointer are valid |
| vec_addr | output | 16 | Vector address of the serviced source |
| sp_new | output | 16 | Stack pointer after the two pushes |

## Verification
The assertions watch these properties on every cycle:
- a request pulse always leaves its pending bit set;
- a dispatch never starts unless the gate was open and an enabled source was pending;
- the gate is shut and exactly one pending bit is gone when a dispatch begins;
- the two stack writes come in descending-address order;
- request, stack write and vector phases never overlap.

Some behaviours depend on the data values and only the bench scenarios, compared against the behavioural reference model, can show them:
- which source wins;
- the exact vector;
- the byte order of the pushed return address;
- write-versus-request collisions;
- gate-open-versus-close precedence.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_REQ     = 3'd1,
      ST_PUSH_HI = 3'd2,
      ST_PUSH_LO = 3'd3,
      ST_VEC     = 3'd4
   } disp_state_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
   parameter int NSRC    = 5,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter logic [ADDR_W-1:0] IE_ADDR = 16'hFFFF,
   parameter logic [ADDR_W-1:0] IF_ADDR = 16'hFF0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NSRC-1:0]   irq_req,
   input  logic              gate_open,
   input  logic              gate_close,
   input  logic              take,
   input  logic [NSRC-1:0]   take_mask,
   output logic [NSRC-1:0]   ie_q,
   output logic [NSRC-1:0]   if_q,
   output logic              gate_q
);
   logic [NSRC-1:0] if_base;
   logic            hit_ie, hit_if;

   assign hit_ie  = (bus_addr == IE_ADDR);
   assign hit_if  = (bus_addr == IF_ADDR);
   assign if_base = (bus_we && hit_if) ? bus_wdata[NSRC-1:0] : if_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q   <= '0;
         if_q   <= '0;
         gate_q <= 1'b0;
      end else begin
         if (bus_we && hit_ie)
            ie_q <= bus_wdata[NSRC-1:0];
         if_q <= (if_base & ~(take ? take_mask : '0)) | irq_req;
         if (take || gate_close)
            gate_q <= 1'b0;
         else if (gate_open)
            gate_q <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_ie) begin
         bus_rdata[NSRC-1:0] = ie_q;
      end else if (hit_if) begin
         bus_rdata           = '1;
         bus_rdata[NSRC-1:0] = if_q;
      end
   end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
   parameter int NSRC      = 5,
   parameter int IDX_W     = 3,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic [NSRC-1:0]  pend,
   output logic             any,
   output logic [IDX_W-1:0] idx,
   output logic [NSRC-1:0]  onehot
);
   assign any = |pend;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_comb begin
            idx = '0;
            for (int i = NSRC - 1; i >= 0; i--)
               if (pend[i]) idx = IDX_W'(i);
         end
      end else begin : g_msb
         always_comb begin
            idx = '0;
            for (int i = 0; i < NSRC; i++)
               if (pend[i]) idx = IDX_W'(i);
         end
      end
   endgenerate

   always_comb begin
      onehot = '0;
      if (any) onehot[idx] = 1'b1;
   end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_pkg::*;
#(
   parameter int NSRC       = 5,
   parameter int IDX_W      = 3,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0040,
   parameter logic [ADDR_W-1:0] VEC_STRIDE = 16'h0008
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  start_idx,
   input  logic              disp_ack,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [ADDR_W-1:0] sp_in,
   output logic              idle,
   output logic              disp_req,
   output logic              wake,
   output logic              push_we,
   output logic [ADDR_W-1:0] push_addr,
   output logic [DATA_W-1:0] push_data,
   output logic              vec_valid,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [ADDR_W-1:0] sp_new
);
   disp_state_t       st_q;
   logic [IDX_W-1:0]  src_q;
   logic [ADDR_W-1:0] pc_q, sp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         src_q <= '0;
         pc_q  <= '0;
         sp_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               st_q  <= ST_REQ;
               src_q <= start_idx;
            end
            ST_REQ: if (disp_ack) begin
               st_q <= ST_PUSH_HI;
               pc_q <= pc_in;
               sp_q <= sp_in;
            end
            ST_PUSH_HI: st_q <= ST_PUSH_LO;
            ST_PUSH_LO: st_q <= ST_VEC;
            default:    st_q <= ST_IDLE;
         endcase
      end
   end

   assign idle      = (st_q == ST_IDLE);
   assign disp_req  = (st_q == ST_REQ);
   assign wake      = (st_q == ST_REQ);
   assign push_we   = (st_q == ST_PUSH_HI) || (st_q == ST_PUSH_LO);
   assign push_addr = (st_q == ST_PUSH_HI) ? sp_q - ADDR_W'(1) : sp_q - ADDR_W'(2);
   assign push_data = (st_q == ST_PUSH_HI) ? pc_q[ADDR_W-1 -: DATA_W] : pc_q[DATA_W-1:0];
   assign vec_valid = (st_q == ST_VEC);
   assign vec_addr  = VEC_BASE + ADDR_W'(src_q) * VEC_STRIDE;
   assign sp_new    = sp_q - ADDR_W'(2);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
   parameter int NSRC      = 5,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter bit LSB_FIRST = 1'b1,
   parameter logic [ADDR_W-1:0] IE_ADDR    = 16'hFFFF,
   parameter logic [ADDR_W-1:0] IF_ADDR    = 16'hFF0F,
   parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0040,
   parameter logic [ADDR_W-1:0] VEC_STRIDE = 16'h0008
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              gate_open,
   input  logic              gate_close,
   input  logic              disp_ack,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [ADDR_W-1:0] sp_in,
   output logic              disp_req,
   output logic              wake,
   output logic              push_we,
   output logic [ADDR_W-1:0] push_addr,
   output logic [DATA_W-1:0] push_data,
   output logic              vec_valid,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [ADDR_W-1:0] sp_new
);
   localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   generate
      if (NSRC < 1 || NSRC >= DATA_W) begin : g_bad_nsrc
         $error("irq_dispatch: NSRC must be between 1 and DATA_W-1");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("irq_dispatch: ADDR_W must be twice DATA_W");
      end
   endgenerate

   logic [NSRC-1:0]  ie_q, if_q, pend, take_mask;
   logic             gate_q, any, idle, take;
   logic [IDX_W-1:0] win_idx;

   irq_regs #(
      .NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .IE_ADDR(IE_ADDR), .IF_ADDR(IF_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
      .gate_open(gate_open), .gate_close(gate_close), .take(take),
      .take_mask(take_mask), .ie_q(ie_q), .if_q(if_q), .gate_q(gate_q)
   );

   assign pend = ie_q & if_q;

   irq_prio #(.NSRC(NSRC), .IDX_W(IDX_W), .LSB_FIRST(LSB_FIRST)) u_prio (
      .pend(pend), .any(any), .idx(win_idx), .onehot(take_mask)
   );

   assign take = idle && gate_q && any;

   irq_seq #(
      .NSRC(NSRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(take), .start_idx(win_idx),
      .disp_ack(disp_ack), .pc_in(pc_in), .sp_in(sp_in), .idle(idle),
      .disp_req(disp_req), .wake(wake), .push_we(push_we),
      .push_addr(push_addr), .push_data(push_data), .vec_valid(vec_valid),
      .vec_addr(vec_addr), .sp_new(sp_new)
   );
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
   parameter int NSRC   = 5,
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0040,
   parameter logic [ADDR_W-1:0] VEC_STRIDE = 16'h0008
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   irq_req,
   input logic              bus_we,
   input logic [NSRC-1:0]   ie_q,
   input logic [NSRC-1:0]   if_q,
   input logic              gate_q,
   input logic              disp_req,
   input logic              wake,
   input logic              push_we,
   input logic [ADDR_W-1:0] push_addr,
   input logic              vec_valid,
   input logic [ADDR_W-1:0] vec_addr
);
   AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_req) |=> ((if_q & $past(irq_req)) == $past(irq_req)));  // R2
   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_req) |-> $past(gate_q && (|(ie_q & if_q))));  // R4
   AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_req) |-> !gate_q);  // R6
   AST_ONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(disp_req) && $past(!bus_we && irq_req == '0))
      |-> ($countones($past(if_q) & ~if_q) == 1));  // R6
   AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (push_we && !$past(push_we)) |=> (push_we && push_addr == $past(push_addr) - ADDR_W'(1)));  // R7
   AST_VEC_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(push_we));  // R7
   AST_PHASES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({disp_req, push_we, vec_valid}));  // R7
   AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> ((vec_addr - VEC_BASE) < ADDR_W'(NSRC) * VEC_STRIDE));  // R5
   AST_WAKE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_req) |-> wake);  // R8
endmodule

bind irq_dispatch irq_dispatch_chk #(
   .NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_we(bus_we),
   .ie_q(ie_q), .if_q(if_q), .gate_q(gate_q), .disp_req(disp_req),
   .wake(wake), .push_we(push_we), .push_addr(push_addr),
   .vec_valid(vec_valid), .vec_addr(vec_addr)
);

// File: tb/sim_irq_dispatch.sv
module sim_irq_dispatch;
   localparam int CLK_P = 10;
   localparam int NSRC  = 5;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  irq_req;
   logic        bus_we, gate_open, gate_close, disp_ack;
   logic [15:0] bus_addr, pc_in, sp_in;
   logic [7:0]  bus_wdata, bus_rdata, push_data;
   logic        disp_req, wake, push_we, vec_valid;
   logic [15:0] push_addr, vec_addr, sp_new;

   int vectors = 0, miscompares = 0;
   bit done = 0;

   // reference model state
   int       m_st;  // 0 idle, 1 request, 2 push high, 3 push low, 4 vector
   bit [4:0] m_ie, m_if;
   bit       m_gate;
   int       m_src;
   bit [15:0] m_pc, m_sp;

   always #(CLK_P/2) clk = ~clk;

   irq_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .gate_open(gate_open), .gate_close(gate_close), .disp_ack(disp_ack),
      .pc_in(pc_in), .sp_in(sp_in), .disp_req(disp_req), .wake(wake),
      .push_we(push_we), .push_addr(push_addr), .push_data(push_data),
      .vec_valid(vec_valid), .vec_addr(vec_addr), .sp_new(sp_new)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle_inputs();
      irq_req = '0; bus_we = 0; bus_addr = 16'h0000; bus_wdata = '0;
      gate_open = 0; gate_close = 0; disp_ack = 0;
   endtask

   task automatic compare_model();
      logic [7:0] exp_rd;
      if (bus_addr == 16'hFFFF)      exp_rd = {3'b000, m_ie};
      else if (bus_addr == 16'hFF0F) exp_rd = {3'b111, m_if};
      else                           exp_rd = 8'h00;
      chk(bus_rdata, exp_rd, (bus_addr == 16'hFF0F) ? "R3 rdata" : "R1 rdata");
      chk(disp_req, m_st == 1, "R4 disp_req");
      chk(wake, m_st == 1, "R8 wake");
      chk(push_we, m_st == 2 || m_st == 3, "R7 push_we");
      if (m_st == 2) begin
         chk(push_addr, m_sp - 16'd1, "R7 push_addr_hi");
         chk(push_data, m_pc[15:8], "R7 push_data_hi");
      end
      if (m_st == 3) begin
         chk(push_addr, m_sp - 16'd2, "R7 push_addr_lo");
         chk(push_data, m_pc[7:0], "R7 push_data_lo");
      end
      chk(vec_valid, m_st == 4, "R7 vec_valid");
      if (m_st == 4) begin
         chk(vec_addr, 16'h0040 + 16'(m_src * 8), "R5 vec_addr");
         chk(sp_new, m_sp - 16'd2, "R7 sp_new");
      end
   endtask

   task automatic model_step();
      bit [4:0] pend, nf;
      bit start;
      int win = 0;
      pend  = m_ie & m_if;
      start = (m_st == 0) && m_gate && (pend != 0);
      for (int i = NSRC - 1; i >= 0; i--) if (pend[i]) win = i;
      nf = (bus_we && bus_addr == 16'hFF0F) ? bus_wdata[4:0] : m_if;
      if (start) nf[win] = 1'b0;
      nf = nf | irq_req;
      if (bus_we && bus_addr == 16'hFFFF) m_ie = bus_wdata[4:0];
      m_if = nf;
      if (start || gate_close) m_gate = 0;
      else if (gate_open)      m_gate = 1;
      case (m_st)
         0: if (start) begin m_st = 1; m_src = win; end
         1: if (disp_ack) begin m_st = 2; m_pc = pc_in; m_sp = sp_in; end
         2: m_st = 3;
         3: m_st = 4;
         default: m_st = 0;
      endcase
   endtask

   // inputs are set before the call; compare, advance model, cross one edge
   task automatic tick();
      #1;
      compare_model();
      model_step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      tick();
      bus_we = 0;
   endtask

   task automatic expect_rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
      bus_addr = a;
      #1;
      chk(bus_rdata, exp, tag);
      tick();
   endtask

   task automatic wait_req();
      for (int k = 0; k < 20 && m_st != 1; k++) tick();
   endtask

   task automatic serve(input logic [15:0] pc, input logic [15:0] sp, input logic [15:0] vec);
      wait_req();
      chk(disp_req, 1'b1, "R4 dispatch started");
      disp_ack = 1; pc_in = pc; sp_in = sp;
      tick();
      disp_ack = 0;
      #1; chk(push_addr, sp - 16'd1, "R7 hi addr"); chk(push_data, pc[15:8], "R7 hi data");
      tick();
      #1; chk(push_addr, sp - 16'd2, "R7 lo addr"); chk(push_data, pc[7:0], "R7 lo data");
      tick();
      #1; chk(vec_addr, vec, "R5 vector"); chk(sp_new, sp - 16'd2, "R7 new sp");
      tick();
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL R7 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      pc_in = '0; sp_in = '0;
      m_st = 0; m_ie = 0; m_if = 0; m_gate = 0; m_src = 0; m_pc = 0; m_sp = 0;
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // reset state
      expect_rd(16'hFFFF, 8'h00, "R1 reset enable");
      expect_rd(16'hFF0F, 8'hE0, "R3 reset pending");
      expect_rd(16'h1234, 8'h00, "R1 unmapped read");

      // register access
      wr(16'hFFFF, 8'hFF);
      expect_rd(16'hFFFF, 8'h1F, "R1 enable readback");
      wr(16'hFF0F, 8'h0A);
      expect_rd(16'hFF0F, 8'hEA, "R3 pending readback");

      // gate closed: nothing dispatches
      repeat (5) tick();
      chk(disp_req, 1'b0, "R4 gate closed");

      // pending but disabled sources are ignored
      wr(16'hFFFF, 8'h00);
      gate_open = 1; tick(); gate_open = 0;
      repeat (5) tick();
      chk(disp_req, 1'b0, "R4 masked sources");
      gate_close = 1; tick(); gate_close = 0;

      // full dispatch of source 2 with delayed acknowledge
      wr(16'hFFFF, 8'h1F);
      wr(16'hFF0F, 8'h14);
      gate_open = 1; tick(); gate_open = 0;
      wait_req();
      repeat (3) tick();
      #1; chk(disp_req, 1'b1, "R7 request held"); chk(wake, 1'b1, "R8 wake held");
      serve(16'h1234, 16'hFFFE, 16'h0050);
      expect_rd(16'hFF0F, 8'hF0, "R6 only serviced bit cleared");
      repeat (4) tick();
      chk(disp_req, 1'b0, "R6 gate stays shut");

      // reopen: remaining source 4
      gate_open = 1; tick(); gate_open = 0;
      serve(16'hABCD, 16'hC000, 16'h0060);
      expect_rd(16'hFF0F, 8'hE0, "R6 source 4 cleared");

      // masking plus priority: only source 3 enabled
      wr(16'hFFFF, 8'h08);
      wr(16'hFF0F, 8'h0F);
      gate_open = 1; tick(); gate_open = 0;
      serve(16'h0100, 16'hFFFE, 16'h0058);
      expect_rd(16'hFF0F, 8'hE7, "R4 disabled bits remain");

      // priority among all enabled
      wr(16'hFFFF, 8'h1F);
      wr(16'hFF0F, 8'h1A);
      gate_open = 1; tick(); gate_open = 0;
      serve(16'h5555, 16'h8000, 16'h0048);

      // write and request in the same cycle: request wins
      irq_req = 5'b00010;
      wr(16'hFF0F, 8'h00);
      irq_req = '0;
      expect_rd(16'hFF0F, 8'hE2, "R2 request beats write");
      wr(16'hFF0F, 8'h00);
      irq_req = 5'b10000; tick(); irq_req = '0;
      expect_rd(16'hFF0F, 8'hF0, "R2 request pulse latched");

      // open and close together: close wins
      wr(16'hFF0F, 8'h01);
      gate_open = 1; gate_close = 1; tick(); gate_open = 0; gate_close = 0;
      repeat (3) tick();
      chk(disp_req, 1'b0, "R9 close wins");
      gate_open = 1; tick(); gate_open = 0;
      serve(16'h2222, 16'h4000, 16'h0040);

      // mixed traffic against the model
      for (int n = 0; n < 4000; n++) begin
         idle_inputs();
         if ($urandom_range(0, 7) == 0) irq_req = 5'($urandom);
         if ($urandom_range(0, 15) == 0) begin
            bus_we = 1;
            bus_addr = $urandom_range(0, 1) ? 16'hFFFF : 16'hFF0F;
            bus_wdata = 8'($urandom);
         end else begin
            bus_addr = $urandom_range(0, 1) ? 16'hFFFF : 16'hFF0F;
         end
         gate_open  = ($urandom_range(0, 5) == 0);
         gate_close = ($urandom_range(0, 11) == 0);
         disp_ack   = ($urandom_range(0, 2) == 0);
         pc_in = 16'($urandom);
         sp_in = 16'($urandom);
         tick();
      end
      idle_inputs();
      tick();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule